// File: doc/BRIEF.md
# Gated Cascadable Event Counter Bank

This block holds four event counters of a configurable width, 16 bits by default. Each counter has its own event input and its own gate input. Both inputs pass through a two-stage synchronizer. A rising edge on the synchronized event input increments that channel's counter once. Each channel has a gate-use enable. When the enable is set, a rising edge is counted only while the synchronized gate is high. When the enable is clear, the gate pin has no effect.

Two static join bits fuse neighbouring channels into double-width counters: one bit for channels 0 and 1, the other for channels 2 and 3. In joined mode the odd channel of the pair becomes the upper half. It advances only when the lower half rolls over from all ones to zero on a counted event, and its own event pin is ignored.

One clear port, made of a strobe and a channel index, zeroes a single counter at the next clock edge. Clearing the lower half of a joined pair also zeroes the upper half. The live counts go out on one flat bus to a read-side capture stage that sits outside this block. A clear acts on the live counters only.

The counters do not start at a known value. The block reset returns only the synchronizer and edge-detect state to idle, so software must issue a clear before it relies on a count.

Top module: `evt_count_bank`

## Requirements
- R1: Each of the four channels counts rising edges of its own event input. A level held high for any number of cycles adds exactly one. Channels do not affect one another when they are not joined.
- R2: With gate_use[c]=1, a rising event edge on channel c is counted only if the synchronized gate_in[c] is high in the same cycle. The gate passes through the same two-stage synchronizer as the event.
- R3: With gate_use[c]=0, gate_in[c] has no effect on channel c's count.
- R4: clr_stb=1 with clr_idx=c sets counter c to zero at the next clock edge. The clear wins over an increment in the same cycle, and it leaves the other counters unchanged.
- R5: With join_cfg[p]=1, channels 2p (lower, count_o bits of that slot) and 2p+1 (upper) form one double-width count. The upper half increments exactly when the lower half wraps from all ones to zero on a counted event.
- R6: In joined mode, the upper channel's own event and gate inputs have no effect on its count.
- R7: In joined mode, a clear addressed to the lower channel zeroes both halves. A clear addressed to the upper channel zeroes only the upper half.
- R8: A counter that is not joined wraps silently from all ones to zero, and that wrap does not change its neighbour.
- R9: Take the first clock edge at which an event input is high after being low. The count changes at the third clock edge counting from that one, and not before.
- R10: rst (synchronous, active high) clears only the synchronizer and edge-detect state. Counter values are left unchanged, and they are undefined until a clear is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the input stages |
| evt_in | input | NUM_CH | Asynchronous event inputs, one per channel |
| gate_in | input | NUM_CH | Asynchronous gate inputs, one per channel |
| gate_use | input | NUM_CH | Per-channel enable: 1 applies the gate, 0 ignores it |
| join_cfg | input | NUM_CH/2 | Static pair join bits: bit p fuses channels 2p and 2p+1 |
| clr_stb | input | 1 | Clear strobe |
| clr_idx | input | $clog2(NUM_CH) | Channel addressed by the clear strobe |
| count_o | output | NUM_CH*CNT_W | Live counts, channel c in bits [c*CNT_W +: CNT_W] |

## Verification
The bench builds the block with NUM_CH=4 and CNT_W=4. Each half then wraps after 16 events and a joined pair fills after 256, so the wrap of a lone counter, the carry into an upper half and the wrap of a whole pair all fall within a short run. The synchronizer depth stays at its default of 2, so the bench checks the three-edge latency exactly as the block is used.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    // Operating mode of one channel pair
    typedef enum logic {
        PAIR_SPLIT  = 1'b0,
        PAIR_JOINED = 1'b1
    } pair_mode_e;

    // Per-counter control for one cycle
    typedef struct packed {
        logic inc;
        logic clr;
    } cnt_ctl_t;

    function automatic int lower_of(input int pair);
        return 2 * pair;
    endfunction

    function automatic int upper_of(input int pair);
        return 2 * pair + 1;
    endfunction

endpackage

// File: rtl/ecb_input_qual.sv
module ecb_input_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_raw,
    input  logic gate_raw,
    input  logic gate_use,
    output logic hit
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] evt_sh;
    logic [LAST:0] gate_sh;
    logic          evt_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_sh   <= '0;
            gate_sh  <= '0;
            evt_prev <= 1'b0;
        end else begin
            evt_sh   <= {evt_sh[LAST-1:0], evt_raw};
            gate_sh  <= {gate_sh[LAST-1:0], gate_raw};
            evt_prev <= evt_sh[LAST];
        end
    end

    always_comb begin
        hit = evt_sh[LAST] & ~evt_prev & (~gate_use | gate_sh[LAST]);
    end

    // R1
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

endmodule

// File: rtl/ecb_counter.sv
module ecb_counter
    import ecb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q;

    // Counter holds no power-up value; only a clear zeroes it
    always_ff @(posedge clk) begin
        if (ctl.clr)
            cnt_q <= '0;
        else if (ctl.inc)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        cnt  = cnt_q;
        wrap = ctl.inc & ~ctl.clr & (cnt_q == ALL_ONES);
    end

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> cnt == '0);

    // R1
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.inc && !ctl.clr) |=> cnt == $past(cnt) + 1'b1);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.inc && !ctl.clr) |=> $stable(cnt));

    // R8
    roll_over_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.inc && !ctl.clr && cnt == ALL_ONES) |=> cnt == '0);

endmodule

// File: rtl/evt_count_bank.sv
module evt_count_bank
    import ecb_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CH-1:0]         evt_in,
    input  logic [NUM_CH-1:0]         gate_in,
    input  logic [NUM_CH-1:0]         gate_use,
    input  logic [NUM_CH/2-1:0]       join_cfg,
    input  logic                      clr_stb,
    input  logic [$clog2(NUM_CH)-1:0] clr_idx,
    output logic [NUM_CH*CNT_W-1:0]   count_o
);
    localparam int NUM_PAIRS = NUM_CH / 2;
    localparam int IDX_W     = $clog2(NUM_CH);

    logic     [NUM_CH-1:0] hit;
    logic     [NUM_CH-1:0] clr_hit;
    logic     [NUM_CH-1:0] wrap;
    cnt_ctl_t [NUM_CH-1:0] ctl;
    logic     [CNT_W-1:0]  cnt [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ecb_input_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
            .clk      (clk),
            .rst      (rst),
            .evt_raw  (evt_in[c]),
            .gate_raw (gate_in[c]),
            .gate_use (gate_use[c]),
            .hit      (hit[c])
        );

        always_comb clr_hit[c] = clr_stb && (clr_idx == IDX_W'(c));

        ecb_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl[c]),
            .cnt  (cnt[c]),
            .wrap (wrap[c])
        );

        always_comb count_o[c*CNT_W +: CNT_W] = cnt[c];
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int LO = lower_of(p);
        localparam int UP = upper_of(p);

        pair_mode_e mode;

        always_comb begin
            mode        = pair_mode_e'(join_cfg[p]);
            ctl[LO].inc = hit[LO];
            ctl[LO].clr = clr_hit[LO];
            if (mode == PAIR_JOINED) begin
                ctl[UP].inc = wrap[LO];
                ctl[UP].clr = clr_hit[UP] | clr_hit[LO];
            end else begin
                ctl[UP].inc = hit[UP];
                ctl[UP].clr = clr_hit[UP];
            end
        end

        // R5
        carry_step_chk: assert property (@(posedge clk) disable iff (rst)
            (join_cfg[p] && hit[LO] && !clr_hit[LO] && !clr_hit[UP] && (&cnt[LO]))
            |=> (cnt[UP] == $past(cnt[UP]) + 1'b1) && (cnt[LO] == '0));

        // R6
        upper_ignore_chk: assert property (@(posedge clk) disable iff (rst)
            (join_cfg[p] && !(hit[LO] && (&cnt[LO])) && !clr_hit[LO] && !clr_hit[UP])
            |=> $stable(cnt[UP]));

        // R7
        pair_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (join_cfg[p] && clr_hit[LO]) |=> (cnt[LO] == '0) && (cnt[UP] == '0));

        // R8
        split_isolate_chk: assert property (@(posedge clk) disable iff (rst)
            (!join_cfg[p] && !hit[UP] && !clr_hit[UP]) |=> $stable(cnt[UP]));
    end

    // R4
    clear_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_hit));

endmodule

// File: tb/tb_evt_count_bank.sv
`timescale 1ns/1ps
module tb_evt_count_bank;
    localparam int NUM_CH = 4;
    localparam int CNT_W  = 4;
    localparam int IDX_W  = 2;
    localparam int MAXV   = (1 << CNT_W) - 1;

    logic                     clk = 1'b0;
    logic                     rst;
    logic [NUM_CH-1:0]        evt_in, gate_in, gate_use;
    logic [NUM_CH/2-1:0]      join_cfg;
    logic                     clr_stb;
    logic [IDX_W-1:0]         clr_idx;
    logic [NUM_CH*CNT_W-1:0]  count_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;
    int exp_cnt [NUM_CH];

    evt_count_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .evt_in(evt_in), .gate_in(gate_in),
        .gate_use(gate_use), .join_cfg(join_cfg), .clr_stb(clr_stb),
        .clr_idx(clr_idx), .count_o(count_o)
    );

    always #4 clk = ~clk;

    function automatic int got(input int c);
        return int'(count_o[c*CNT_W +: CNT_W]);
    endfunction

    task automatic check_one(input string req, input int c, input int expv);
        checks++;
        if (got(c) != expv) begin
            failures++;
            $display("FAIL %s ch%0d actual=%0d expected=%0d", req, c, got(c), expv);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NUM_CH; c++) check_one(req, c, exp_cnt[c]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Model of one pulse on the masked channels
    task automatic model_pulse(input logic [NUM_CH-1:0] mask);
        for (int p = 0; p < NUM_CH/2; p++) begin
            bit hlo, hup, carry;
            hlo   = mask[2*p]   && (!gate_use[2*p]   || gate_in[2*p]);
            hup   = mask[2*p+1] && (!gate_use[2*p+1] || gate_in[2*p+1]);
            carry = hlo && (exp_cnt[2*p] == MAXV);
            if (hlo) exp_cnt[2*p] = (exp_cnt[2*p] + 1) & MAXV;
            if (join_cfg[p] ? carry : hup)
                exp_cnt[2*p+1] = (exp_cnt[2*p+1] + 1) & MAXV;
        end
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); evt_in = mask;
            idle(1);        evt_in = '0;
            idle(2);
            model_pulse(mask);
        end
        idle(3);
    endtask

    task automatic clear(input int c);
        @(negedge clk); clr_stb = 1'b1; clr_idx = IDX_W'(c);
        @(negedge clk); clr_stb = 1'b0;
        exp_cnt[c] = 0;
        if (c % 2 == 0 && join_cfg[c/2]) exp_cnt[c+1] = 0;
    endtask

    task automatic t_init_clear();
        for (int c = 0; c < NUM_CH; c++) clear(c);
        idle(1);
        check_all("R4 initial clear");
    endtask

    task automatic t_basic();
        pulse(4'b0001, 3);
        pulse(4'b0110, 2);
        pulse(4'b1111, 1);
        check_all("R1 independent counts");
        // long high level counts once
        @(negedge clk); evt_in = 4'b1000;
        idle(10); evt_in = '0; idle(4);
        model_pulse(4'b1000);
        check_one("R1 held level", 3, exp_cnt[3]);
    endtask

    task automatic t_gate();
        gate_use = 4'b0011; gate_in = 4'b0001; idle(4);
        pulse(4'b0011, 2);
        check_one("R2 gate open", 0, exp_cnt[0]);
        check_one("R2 gate closed", 1, exp_cnt[1]);
        gate_use = 4'b0000; gate_in = 4'b0000; idle(4);
        pulse(4'b1100, 2);
        check_one("R3 gate ignored", 2, exp_cnt[2]);
        check_one("R3 gate ignored", 3, exp_cnt[3]);
    endtask

    task automatic t_clear();
        clear(1); idle(1);
        check_all("R4 single clear");
    endtask

    task automatic t_wrap16();
        clear(2); clear(3);
        pulse(4'b0100, 17);
        check_one("R8 split wrap", 2, 1);
        check_one("R8 neighbour kept", 3, 0);
    endtask

    task automatic t_join();
        join_cfg = 2'b01; idle(2);
        clear(0);
        check_one("R7 pair clear up", 1, 0);
        pulse(4'b0011, 20);
        check_one("R5 lower", 0, 4);
        check_one("R5 upper carry", 1, 1);
        pulse(4'b0010, 3);
        check_one("R6 upper own event", 1, 1);
        clear(1); idle(1);
        check_one("R7 upper clear only up", 1, 0);
        check_one("R7 upper clear keeps low", 0, 4);
        pulse(4'b0001, 12);
        check_one("R5 second carry", 1, 1);
        clear(0); idle(1);
        check_one("R7 lower clear low", 0, 0);
        check_one("R7 lower clear up", 1, 0);
        join_cfg = 2'b00; idle(2);
    endtask

    task automatic t_latency();
        int base;
        clear(0); idle(2);
        base = got(0);
        @(negedge clk); evt_in = 4'b0001;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check_one("R9 not before third edge", 0, base);
        @(posedge clk); @(negedge clk);
        check_one("R9 third edge", 0, base + 1);
        evt_in = '0; idle(4);
        exp_cnt[0] = base + 1;
    endtask

    task automatic t_priority();
        @(negedge clk); evt_in = 4'b0001;
        @(posedge clk); @(posedge clk); @(negedge clk);
        clr_stb = 1'b1; clr_idx = 2'd0;
        @(negedge clk); clr_stb = 1'b0;
        check_one("R4 clear beats increment", 0, 0);
        evt_in = '0; idle(4);
        exp_cnt[0] = 0;
        check_all("R4 after collision");
    endtask

    task automatic t_rst_hold();
        pulse(4'b1111, 2);
        @(negedge clk); rst = 1'b1;
        idle(2); rst = 1'b0; idle(2);
        check_all("R10 rst keeps counts");
    endtask

    initial begin
        rst = 1'b1; evt_in = '0; gate_in = '0; gate_use = '0;
        join_cfg = '0; clr_stb = 1'b0; clr_idx = '0;
        for (int c = 0; c < NUM_CH; c++) exp_cnt[c] = 0;
        idle(3); rst = 1'b0; idle(2);
        t_init_clear();
        t_basic();
        t_gate();
        t_clear();
        t_wrap16();
        t_join();
        t_latency();
        t_priority();
        t_rst_hold();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule